// File: doc/BRIEF.md
# Phase-Cut Dimmer Type Classifier

This block decides how the mains line reaches a lamp driver: through a plain switch, through a dimmer that cuts the start of each half-cycle (leading edge), or through one that cuts the end (trailing edge). It sees a stream of digitized rectified-line samples, a strobe that marks each half-cycle boundary and a supply-good flag. It drives a registered operating mode and a flag that shows whether the decision is settled (validating) or still being learned.

After the supply comes up, the block learns over a short run of half-cycles and picks the most frequent per-half-cycle verdict. It then validates its choice. Every half-cycle's verdict feeds a saturating up/down counter per candidate mode, and the counters are inspected once per check period. If a mode other than the active one has filled its counter at that moment, the block goes back to learning. It keeps the old mode until the new learn run ends. A single noisy half-cycle therefore cannot change the mode.

Top module: `dimmer_classifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `mode` is 0 and `validating` is 0. Mode codes: 0 = no dimmer, 1 = leading edge, 2 = trailing edge.
- R2: After supply-good rises, the first `half_start` strobe only opens a half-cycle and casts no vote. The next LEARN_HALVES strobes each cast one vote. On the last of them `validating` rises, one cycle after that strobe.
- R3: A half-cycle votes leading edge when two consecutive valid samples inside it go from strictly below LOW_LEVEL to strictly above HIGH_LEVEL. A sample equal to either level does not count.
- R4: A half-cycle votes trailing edge when two consecutive valid samples inside it go from strictly above HIGH_LEVEL to strictly below LOW_LEVEL. A half-cycle with neither pattern votes no dimmer. A half-cycle with both patterns votes leading edge. Sample pairs never span a `half_start` strobe.
- R5: At the end of a learn run, `mode` takes the candidate with the most votes. On a tie the lower code wins.
- R6: `mode` changes only at the end of a learn run or when supply-good is low. `validating` is 1 exactly while the block is in its validate phase.
- R7: In the validate phase, each strobe moves every candidate's counter up by one when the verdict names that candidate and down by one otherwise. The counters saturate at 0 and FILTER_DEPTH. Only on every CHECK_PERIOD-th strobe is a full counter of a non-active candidate acted on. The block then drops `validating` and relearns over the next LEARN_HALVES strobes, keeping the old `mode` meanwhile.
- R8: Isolated or alternating disagreeing verdicts that never fill a counter by the check strobe leave `mode` and `validating` unchanged.
- R9: Supply-good low at a clock edge sets `mode` to 0 and `validating` to 0 and restarts learning as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag; low holds the block in its start state |
| sample_valid | input | 1 | Qualifies `sample` |
| sample | input | SAMPLE_W | Digitized rectified-line level |
| half_start | input | 1 | One-cycle strobe at each half-cycle boundary |
| mode | output | 2 | Operating mode: 0 none, 1 leading, 2 trailing |
| validating | output | 1 | 1 in validate phase, 0 while learning |

## Verification
The bench builds the block with LEARN_HALVES=4, FILTER_DEPTH=4 and CHECK_PERIOD=8, using eight samples per half-cycle. With these values a full learn run, several check periods and two relearn runs fit in a few hundred half-cycles. One period is long enough to show that a counter that fills before the check strobe is not acted on until that strobe. Another period shows that an alternating pattern drains a counter before the check. The level thresholds stay at 40 and 200, so half-cycles with steps that land exactly on 39→200 and 201→40 probe the strict comparisons.

// File: rtl/dimclass_pkg.sv
package dimclass_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_LEAD  = 2'd1,
        MODE_TRAIL = 2'd2
    } line_mode_e;

    localparam int NUM_MODES = 3;

    typedef enum logic {
        PH_LEARN = 1'b0,
        PH_CHECK = 1'b1
    } phase_e;

    // Verdict of one half-cycle; a steep rise outranks a steep fall.
    function automatic line_mode_e half_verdict(input logic saw_rise, input logic saw_fall);
        if (saw_rise)
            return MODE_LEAD;
        else if (saw_fall)
            return MODE_TRAIL;
        return MODE_PLAIN;
    endfunction

    function automatic logic [NUM_MODES-1:0] mode_onehot(input line_mode_e m);
        return 3'b001 << m;
    endfunction

endpackage

// File: rtl/edge_scanner.sv
module edge_scanner
    import dimclass_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int LOW_LEVEL  = 40,
    parameter int HIGH_LEVEL = 200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp,
    input  logic                boundary,
    output line_mode_e          verdict
);

    localparam logic [SAMPLE_W-1:0] LO_V = SAMPLE_W'(LOW_LEVEL);
    localparam logic [SAMPLE_W-1:0] HI_V = SAMPLE_W'(HIGH_LEVEL);

    logic [SAMPLE_W-1:0] prev_q;
    logic                have_prev_q;
    logic                rise_q;
    logic                fall_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            rise_q      <= 1'b0;
            fall_q      <= 1'b0;
        end else if (boundary) begin
            // New half-cycle: forget flags; a sample here opens the next pair
            rise_q      <= 1'b0;
            fall_q      <= 1'b0;
            have_prev_q <= smp_valid;
            if (smp_valid)
                prev_q <= smp;
        end else if (smp_valid) begin
            if (have_prev_q && (prev_q < LO_V) && (smp > HI_V))
                rise_q <= 1'b1;
            if (have_prev_q && (prev_q > HI_V) && (smp < LO_V))
                fall_q <= 1'b1;
            prev_q      <= smp;
            have_prev_q <= 1'b1;
        end
    end

    assign verdict = half_verdict(rise_q, fall_q);

endmodule

// File: rtl/vote_bank.sv
module vote_bank
    import dimclass_pkg::*;
#(
    parameter int FILTER_DEPTH = 8,
    parameter int CNT_W        = $clog2(FILTER_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 step,
    input  logic                 accumulate,
    input  line_mode_e           verdict,
    output logic [CNT_W-1:0]     tally_nxt [NUM_MODES],
    output logic [NUM_MODES-1:0] full_nxt
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILTER_DEPTH);

    genvar g;
    generate
        for (g = 0; g < NUM_MODES; g++) begin : g_cand
            logic [CNT_W-1:0] cnt_q;

            always_comb begin
                tally_nxt[g] = cnt_q;
                if (step) begin
                    if (verdict == line_mode_e'(2'(g))) begin
                        if (cnt_q != CNT_MAX)
                            tally_nxt[g] = cnt_q + 1'b1;
                    end else if (!accumulate && (cnt_q != '0)) begin
                        tally_nxt[g] = cnt_q - 1'b1;
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst || clr)
                    cnt_q <= '0;
                else
                    cnt_q <= tally_nxt[g];
            end

            assign full_nxt[g] = (tally_nxt[g] == CNT_MAX);
        end
    endgenerate

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import dimclass_pkg::*;
#(
    parameter int LEARN_HALVES = 4,
    parameter int CHECK_PERIOD = 64,
    parameter int CNT_W        = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 supply_ok,
    input  logic                 boundary,
    input  logic [CNT_W-1:0]     tally_nxt [NUM_MODES],
    input  logic [NUM_MODES-1:0] full_nxt,
    output line_mode_e           mode,
    output logic                 validating,
    output logic                 flt_clr,
    output logic                 flt_step,
    output logic                 accumulate
);

    localparam int LW = $clog2(LEARN_HALVES + 1);
    localparam int PW = $clog2(CHECK_PERIOD);
    localparam logic [LW-1:0] LEARN_LAST = LW'(LEARN_HALVES);
    localparam logic [PW-1:0] CHECK_LAST = PW'(CHECK_PERIOD - 1);

    phase_e      phase_q;
    line_mode_e  mode_q;
    logic [LW-1:0] lcnt_q;
    logic [PW-1:0] pcnt_q;

    line_mode_e       winner;
    logic [CNT_W-1:0] best_cnt;
    logic             wrong_mode;
    logic             learn_open;
    logic             learn_done;
    logic             check_tick;

    always_comb begin
        winner   = MODE_PLAIN;
        best_cnt = tally_nxt[0];
        if (tally_nxt[1] > best_cnt) begin
            winner   = MODE_LEAD;
            best_cnt = tally_nxt[1];
        end
        if (tally_nxt[2] > best_cnt) begin
            winner   = MODE_TRAIL;
            best_cnt = tally_nxt[2];
        end
    end

    assign wrong_mode = |(full_nxt & ~mode_onehot(mode_q));
    assign learn_open = (phase_q == PH_LEARN) && (lcnt_q == '0);
    assign learn_done = (phase_q == PH_LEARN) && (lcnt_q == LEARN_LAST);
    assign check_tick = (phase_q == PH_CHECK) && (pcnt_q == CHECK_LAST);

    assign accumulate = (phase_q == PH_LEARN);
    assign flt_step   = boundary && !learn_open;
    assign flt_clr    = !supply_ok ||
                        (boundary && (learn_open || learn_done || (check_tick && wrong_mode)));

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            phase_q <= PH_LEARN;
            mode_q  <= MODE_PLAIN;
            lcnt_q  <= '0;
            pcnt_q  <= '0;
        end else if (boundary) begin
            case (phase_q)
                PH_LEARN: begin
                    if (learn_done) begin
                        mode_q  <= winner;
                        phase_q <= PH_CHECK;
                        pcnt_q  <= '0;
                    end else begin
                        lcnt_q <= lcnt_q + 1'b1;
                    end
                end
                default: begin
                    if (check_tick) begin
                        pcnt_q <= '0;
                        if (wrong_mode) begin
                            phase_q <= PH_LEARN;
                            lcnt_q  <= LW'(1);
                        end
                    end else begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign mode       = mode_q;
    assign validating = (phase_q == PH_CHECK);

endmodule

// File: rtl/dimmer_classifier.sv
module dimmer_classifier
    import dimclass_pkg::*;
#(
    parameter int SAMPLE_W     = 8,
    parameter int LOW_LEVEL    = 40,
    parameter int HIGH_LEVEL   = 200,
    parameter int LEARN_HALVES = 4,
    parameter int FILTER_DEPTH = 8,
    parameter int CHECK_PERIOD = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                supply_ok,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                half_start,
    output logic [1:0]          mode,
    output logic                validating
);

    localparam int CNT_W = $clog2(FILTER_DEPTH + 1);

    line_mode_e           verdict;
    line_mode_e           mode_int;
    logic [CNT_W-1:0]     tally_nxt [NUM_MODES];
    logic [NUM_MODES-1:0] full_nxt;
    logic                 flt_clr;
    logic                 flt_step;
    logic                 accumulate;

    edge_scanner #(
        .SAMPLE_W  (SAMPLE_W),
        .LOW_LEVEL (LOW_LEVEL),
        .HIGH_LEVEL(HIGH_LEVEL)
    ) u_scan (
        .clk      (clk),
        .rst      (rst),
        .clr      (!supply_ok),
        .smp_valid(sample_valid),
        .smp      (sample),
        .boundary (half_start),
        .verdict  (verdict)
    );

    vote_bank #(
        .FILTER_DEPTH(FILTER_DEPTH),
        .CNT_W       (CNT_W)
    ) u_votes (
        .clk       (clk),
        .rst       (rst),
        .clr       (flt_clr),
        .step      (flt_step),
        .accumulate(accumulate),
        .verdict   (verdict),
        .tally_nxt (tally_nxt),
        .full_nxt  (full_nxt)
    );

    mode_fsm #(
        .LEARN_HALVES(LEARN_HALVES),
        .CHECK_PERIOD(CHECK_PERIOD),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .boundary  (half_start),
        .tally_nxt (tally_nxt),
        .full_nxt  (full_nxt),
        .mode      (mode_int),
        .validating(validating),
        .flt_clr   (flt_clr),
        .flt_step  (flt_step),
        .accumulate(accumulate)
    );

    assign mode = mode_int;

endmodule

// File: rtl/dimmer_classifier_props.sv
module dimmer_classifier_props (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       half_start,
    input logic [1:0] mode,
    input logic       validating
);

    // R9: a low supply-good flag puts the block back into its start state
    assert_supply_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (mode == 2'd0 && !validating));

    // R6: mode moves only at the end of a learn run
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && (validating || !half_start)) |=> $stable(mode));

    // R2: validate phase is entered only on a strobe
    assert_enter_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && !validating && !half_start) |=> !validating);

    // R7: validate phase is left only on a strobe
    assert_leave_on_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && validating && !half_start) |=> validating);

    // R5: only the three defined mode codes appear
    assert_mode_code_R5: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd3);

endmodule

bind dimmer_classifier dimmer_classifier_props u_props (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .half_start(half_start),
    .mode      (mode),
    .validating(validating)
);

// File: tb/dimmer_classifier_test.sv
module dimmer_classifier_test;

    localparam int CLK_PERIOD = 10;
    localparam int K_PLAIN = 0;
    localparam int K_LEAD  = 1;
    localparam int K_TRAIL = 2;
    localparam int K_NEAR  = 3;

    typedef struct {
        logic [1:0] m;
        logic       v;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b0;
    logic       sample_valid = 1'b0;
    logic [7:0] sample = '0;
    logic       half_start = 1'b0;
    logic [1:0] mode;
    logic       validating;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t q[$];

    dimmer_classifier #(
        .SAMPLE_W    (8),
        .LOW_LEVEL   (40),
        .HIGH_LEVEL  (200),
        .LEARN_HALVES(4),
        .FILTER_DEPTH(4),
        .CHECK_PERIOD(8)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .sample_valid(sample_valid),
        .sample      (sample),
        .half_start  (half_start),
        .mode        (mode),
        .validating  (validating)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] wave(input int kind, input int idx);
        case (kind)
            K_LEAD:  case (idx) 0,1,2: return 8'd0; 3: return 8'd230; 4: return 8'd240;
                                5: return 8'd180; 6: return 8'd120; default: return 8'd60; endcase
            K_TRAIL: case (idx) 0: return 8'd10; 1: return 8'd60; 2: return 8'd120; 3: return 8'd180;
                                4: return 8'd230; 5: return 8'd220; default: return 8'd0; endcase
            K_NEAR:  case (idx) 0: return 8'd0; 1: return 8'd39; 2: return 8'd200; 3: return 8'd220;
                                4: return 8'd201; 5: return 8'd40; 6: return 8'd30; default: return 8'd20; endcase
            default: case (idx) 0: return 8'd10; 1: return 8'd60; 2: return 8'd120; 3: return 8'd180;
                                4: return 8'd220; 5: return 8'd180; 6: return 8'd120; default: return 8'd60; endcase
        endcase
    endfunction

    task automatic compare(input string tag, input logic [1:0] em, input logic ev);
        checks++;
        if (mode !== em || validating !== ev) begin
            fails++;
            $display("FAIL %s: mode=%0d validating=%0d expected mode=%0d validating=%0d",
                     tag, mode, validating, em, ev);
        end
    endtask

    // Driver: one half-cycle of samples, then the boundary strobe; expectation queued
    task automatic half(input int kind, input logic [1:0] em, input logic ev, input string tag);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sample_valid = 1'b1;
            sample = wave(kind, i);
        end
        @(negedge clk);
        sample_valid = 1'b0;
        half_start = 1'b1;
        @(negedge clk);
        half_start = 1'b0;
        q.push_back('{m: em, v: ev, tag: tag});
    endtask

    // Monitor: compares outputs against queued expectations away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compare(e.tag, e.m, e.v);
            end
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1 reset state", 2'd0, 1'b0);
        supply_ok = 1'b1;
        repeat (2) @(negedge clk);
        compare("R1 supply up, no strobe yet", 2'd0, 1'b0);

        // Learn: opening strobe then four leading-edge votes
        half(K_LEAD, 2'd0, 1'b0, "R2 opening strobe casts no vote");
        for (int i = 0; i < 3; i++) half(K_LEAD, 2'd0, 1'b0, "R2 still learning");
        half(K_LEAD, 2'd1, 1'b1, "R3 R5 learned leading edge");

        // Alternating disagreement never fills a counter
        half(K_TRAIL, 2'd1, 1'b1, "R8 transient");
        half(K_LEAD,  2'd1, 1'b1, "R8 transient");
        half(K_TRAIL, 2'd1, 1'b1, "R8 transient");
        half(K_LEAD,  2'd1, 1'b1, "R8 transient");
        half(K_PLAIN, 2'd1, 1'b1, "R8 transient");
        half(K_LEAD,  2'd1, 1'b1, "R8 transient");
        half(K_TRAIL, 2'd1, 1'b1, "R8 transient");
        half(K_LEAD,  2'd1, 1'b1, "R8 check strobe keeps mode");

        // Persistent plain line: counter fills early but acts only on the check strobe
        for (int i = 0; i < 7; i++) half(K_PLAIN, 2'd1, 1'b1, "R7 waits for check strobe");
        half(K_PLAIN, 2'd1, 1'b0, "R7 wrong mode sends back to learn");

        // Relearn: three trailing votes, one plain
        for (int i = 0; i < 3; i++) half(K_TRAIL, 2'd1, 1'b0, "R7 old mode held while relearning");
        half(K_PLAIN, 2'd2, 1'b1, "R4 R5 learned trailing edge");

        // Up/down filter: lead counter peaks at 4 mid-period then drains to 2
        half(K_LEAD,  2'd2, 1'b1, "R7 up/down");
        half(K_LEAD,  2'd2, 1'b1, "R7 up/down");
        half(K_LEAD,  2'd2, 1'b1, "R7 up/down");
        half(K_PLAIN, 2'd2, 1'b1, "R7 up/down");
        half(K_LEAD,  2'd2, 1'b1, "R7 up/down");
        half(K_LEAD,  2'd2, 1'b1, "R7 full counter off-tick ignored");
        half(K_PLAIN, 2'd2, 1'b1, "R7 up/down");
        half(K_PLAIN, 2'd2, 1'b1, "R7 drained counter at check strobe");

        // Supply drop
        drain();
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        compare("R9 supply drop", 2'd0, 1'b0);
        supply_ok = 1'b1;

        // Steps landing exactly on the levels vote no dimmer
        half(K_NEAR, 2'd0, 1'b0, "R9 R2 relearn opening strobe");
        for (int i = 0; i < 3; i++) half(K_NEAR, 2'd0, 1'b0, "R3 R4 learning");
        half(K_NEAR, 2'd0, 1'b1, "R3 R4 strict thresholds give no dimmer");

        // Persistent leading edge forces relearn
        for (int i = 0; i < 7; i++) half(K_LEAD, 2'd0, 1'b1, "R7 waits for check strobe");
        half(K_LEAD, 2'd0, 1'b0, "R7 wrong mode sends back to learn");

        // Tie between leading and trailing: lower code wins
        half(K_LEAD,  2'd0, 1'b0, "R5 tie learning");
        half(K_TRAIL, 2'd0, 1'b0, "R5 tie learning");
        half(K_LEAD,  2'd0, 1'b0, "R5 tie learning");
        half(K_TRAIL, 2'd1, 1'b1, "R5 tie goes to lower code");

        drain();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule